// File: doc/BRIEF.md
# Dual-Channel Receive Queue Address Manager

This block keeps track of two receive queues, one for each of two bus channels. Both queues are carved out of one shared message-buffer memory. For each channel it stores where the queue starts, how many entries it has and how many bytes each entry takes. It keeps a write pointer and a read pointer per queue, and from these it forms two memory addresses: the slot where the next received entry goes, and the oldest entry, which is the next one to read. One mode bit chooses the base address that is added to every address. The base is either a common system base or a base reserved for the receive queues.

Software programs the geometry through a small register write port. Writes take effect only while the controller reports its configuration state. While the controller runs, the frame-handling logic sends one push strobe per stored entry and the host side sends one pop strobe per consumed entry, each per channel. The two channels never interact. The block reports a fill count and a not-empty flag per channel, plus sticky overflow and underflow flags.

Top module: `rxq_addr_mgr`

## Requirements
- R1: After synchronous reset, every register, pointer, count and flag is zero. Both address outputs of each channel are therefore 0.
- R2: Each channel drives a write address equal to base + (start + write pointer) × entry size, and a read address equal to base + (start + read pointer) × entry size. Both are taken modulo 2^ADDR_W.
- R3: The mode bit is bit 0 of register select 0. When it is 0, the base is the common base (select 1). When it is 1, the base is the dedicated queue base (select 2). The chosen base applies to both channels.
- R4: Register selects: 3 is the channel A start index, 4 is the channel A geometry, 5 is the channel B start index, 6 is the channel B geometry. A geometry register holds the entry size in bits 7:0 and the depth in bits 15:8. A write with cfg_we high while cfg_mode is high updates the register on the next clock edge.
- R5: A write with cfg_we high while cfg_mode is low changes no register. cfg_err is high for exactly the one cycle that follows such a write, and is low otherwise.
- R6: An accepted push advances the write pointer and an accepted pop advances the read pointer. Each pointer wraps from depth − 1 to 0.
- R7: A push while the count equals the depth is dropped and sets that channel's overflow flag. The flag stays set until configuration state is entered.
- R8: A pop while the count is 0 is ignored and sets that channel's underflow flag. The flag stays set until configuration state is entered.
- R9: The count output equals accepted pushes minus accepted pops since configuration state was last left. not_empty is high exactly when the count is non-zero.
- R10: Strobes on one channel never change the outputs of the other channel.
- R11: While cfg_mode is high, push and pop are ignored, and pointers, counts and sticky flags are held at 0. A queue therefore starts empty at pointer 0 when configuration state is left.
- R12: When push and pop arrive in the same cycle, both are judged against the count from before that cycle. On an empty queue the push is accepted and the pop underflows. On a full queue the pop is accepted and the push overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | High while the controller is in configuration state |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_err | output | 1 | One-cycle pulse after a rejected write |
| a_push | input | 1 | Channel A entry stored |
| a_pop | input | 1 | Channel A entry consumed |
| a_wr_addr | output | ADDR_W | Channel A next-fill address |
| a_rd_addr | output | ADDR_W | Channel A oldest-entry address |
| a_not_empty | output | 1 | Channel A holds at least one entry |
| a_count | output | DEPTH_W+1 | Channel A fill count |
| a_ovf | output | 1 | Channel A sticky overflow |
| a_unf | output | 1 | Channel A sticky underflow |
| b_push | input | 1 | Channel B entry stored |
| b_pop | input | 1 | Channel B entry consumed |
| b_wr_addr | output | ADDR_W | Channel B next-fill address |
| b_rd_addr | output | ADDR_W | Channel B oldest-entry address |
| b_not_empty | output | 1 | Channel B holds at least one entry |
| b_count | output | DEPTH_W+1 | Channel B fill count |
| b_ovf | output | 1 | Channel B sticky overflow |
| b_unf | output | 1 | Channel B sticky underflow |

## Verification
A pointer that slips or wraps at the wrong place shows up on the address outputs in the same cycle as the faulty clock edge, because the addresses are formed combinationally from the pointer registers. A wrong count shows up on the next cycle as a count mismatch, or as an overflow or underflow flag at the wrong time. A configuration field that is latched wrongly, or a write that should have been rejected but landed, shifts every address from then on. The bench compares every output against a behavioural model after every clock, so each of these faults is reported within one cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int NUM_CH = 2;

    // register select codes
    typedef enum logic [2:0] {
        SEL_MODE       = 3'd0,
        SEL_BASE_SYS   = 3'd1,
        SEL_BASE_QUEUE = 3'd2,
        SEL_CH_FIRST   = 3'd3
    } reg_sel_e;

    // per-channel sticky error flags
    typedef struct packed {
        logic ovf;
        logic unf;
    } ch_flags_t;

    // start-index select of channel ch; geometry select is the next code
    function automatic logic [2:0] start_sel(int ch);
        return 3'(int'(SEL_CH_FIRST) + 2 * ch);
    endfunction

    function automatic logic [2:0] geom_sel(int ch);
        return 3'(int'(SEL_CH_FIRST) + 2 * ch + 1);
    endfunction

    // base + (start + ptr) * size, computed in 32 bits and truncated by caller
    function automatic logic [31:0] entry_addr(logic [31:0] base, logic [31:0] start,
                                               logic [31:0] ptr, logic [31:0] size);
        return base + (start + ptr) * size;
    endfunction

endpackage

// File: rtl/rxq_cfg_regs.sv
module rxq_cfg_regs
    import rxq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 8,
    parameter int DEPTH_W = 8,
    parameter int SIZE_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_mode,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic               cfg_err,
    output logic [ADDR_W-1:0]  base_addr,
    output logic [IDX_W-1:0]   start_idx [NUM_CH],
    output logic [DEPTH_W-1:0] depth     [NUM_CH],
    output logic [SIZE_W-1:0]  ent_size  [NUM_CH]
);

    logic              base_pick;
    logic [ADDR_W-1:0] base_sys_q;
    logic [ADDR_W-1:0] base_queue_q;
    logic              wr_ok;

    assign wr_ok = cfg_we && cfg_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err      <= 1'b0;
            base_pick    <= 1'b0;
            base_sys_q   <= '0;
            base_queue_q <= '0;
        end else begin
            cfg_err <= cfg_we && !cfg_mode;
            if (wr_ok) begin
                case (cfg_sel)
                    SEL_MODE:       base_pick    <= cfg_wdata[0];
                    SEL_BASE_SYS:   base_sys_q   <= cfg_wdata[ADDR_W-1:0];
                    SEL_BASE_QUEUE: base_queue_q <= cfg_wdata[ADDR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign base_addr = base_pick ? base_queue_q : base_sys_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                start_idx[ch] <= '0;
                depth[ch]     <= '0;
                ent_size[ch]  <= '0;
            end else if (wr_ok) begin
                if (cfg_sel == start_sel(ch)) begin
                    start_idx[ch] <= cfg_wdata[IDX_W-1:0];
                end
                if (cfg_sel == geom_sel(ch)) begin
                    ent_size[ch] <= cfg_wdata[SIZE_W-1:0];
                    depth[ch]    <= cfg_wdata[SIZE_W +: DEPTH_W];
                end
            end
        end
    end

endmodule

// File: rtl/rxq_chan_ptr.sv
module rxq_chan_ptr
    import rxq_pkg::*;
#(
    parameter int DEPTH_W = 8,
    localparam int CNT_W  = DEPTH_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_mode,
    input  logic               push,
    input  logic               pop,
    input  logic [DEPTH_W-1:0] depth,
    output logic [DEPTH_W-1:0] wr_ptr,
    output logic [DEPTH_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]   count,
    output ch_flags_t          flags
);

    logic full, empty, do_push, do_pop;
    logic [DEPTH_W-1:0] last_idx;

    assign full     = (count == {1'b0, depth});
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign last_idx = depth - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || cfg_mode) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            flags  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == last_idx) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == last_idx) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
            if (push && full) flags.ovf <= 1'b1;
            if (pop && empty) flags.unf <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen
    import rxq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 8,
    parameter int DEPTH_W = 8,
    parameter int SIZE_W  = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [IDX_W-1:0]   start,
    input  logic [DEPTH_W-1:0] ptr,
    input  logic [SIZE_W-1:0]  size,
    output logic [ADDR_W-1:0]  addr
);

    logic [31:0] full_addr;

    assign full_addr = entry_addr(32'(base), 32'(start), 32'(ptr), 32'(size));
    assign addr      = full_addr[ADDR_W-1:0];

endmodule

// File: rtl/rxq_addr_mgr.sv
module rxq_addr_mgr
    import rxq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 8,
    parameter int DEPTH_W = 8,
    parameter int SIZE_W  = 8,
    localparam int CNT_W  = DEPTH_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_mode,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic               cfg_err,
    input  logic               a_push,
    input  logic               a_pop,
    output logic [ADDR_W-1:0]  a_wr_addr,
    output logic [ADDR_W-1:0]  a_rd_addr,
    output logic               a_not_empty,
    output logic [CNT_W-1:0]   a_count,
    output logic               a_ovf,
    output logic               a_unf,
    input  logic               b_push,
    input  logic               b_pop,
    output logic [ADDR_W-1:0]  b_wr_addr,
    output logic [ADDR_W-1:0]  b_rd_addr,
    output logic               b_not_empty,
    output logic [CNT_W-1:0]   b_count,
    output logic               b_ovf,
    output logic               b_unf
);

    logic [ADDR_W-1:0]  base_addr;
    logic [IDX_W-1:0]   start_idx [NUM_CH];
    logic [DEPTH_W-1:0] depth     [NUM_CH];
    logic [SIZE_W-1:0]  ent_size  [NUM_CH];

    logic               push_v    [NUM_CH];
    logic               pop_v     [NUM_CH];
    logic [DEPTH_W-1:0] wr_ptr    [NUM_CH];
    logic [DEPTH_W-1:0] rd_ptr    [NUM_CH];
    logic [CNT_W-1:0]   count_v   [NUM_CH];
    ch_flags_t          flags_v   [NUM_CH];
    logic [ADDR_W-1:0]  wr_addr_v [NUM_CH];
    logic [ADDR_W-1:0]  rd_addr_v [NUM_CH];

    rxq_cfg_regs #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .IDX_W (IDX_W),
        .DEPTH_W(DEPTH_W), .SIZE_W (SIZE_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .cfg_err  (cfg_err),
        .base_addr(base_addr),
        .start_idx(start_idx),
        .depth    (depth),
        .ent_size (ent_size)
    );

    assign push_v[0] = a_push;
    assign pop_v[0]  = a_pop;
    assign push_v[1] = b_push;
    assign pop_v[1]  = b_pop;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        rxq_chan_ptr #(.DEPTH_W(DEPTH_W)) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .cfg_mode(cfg_mode),
            .push    (push_v[ch]),
            .pop     (pop_v[ch]),
            .depth   (depth[ch]),
            .wr_ptr  (wr_ptr[ch]),
            .rd_ptr  (rd_ptr[ch]),
            .count   (count_v[ch]),
            .flags   (flags_v[ch])
        );

        rxq_addr_gen #(
            .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W)
        ) u_wr_addr (
            .base (base_addr),
            .start(start_idx[ch]),
            .ptr  (wr_ptr[ch]),
            .size (ent_size[ch]),
            .addr (wr_addr_v[ch])
        );

        rxq_addr_gen #(
            .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W)
        ) u_rd_addr (
            .base (base_addr),
            .start(start_idx[ch]),
            .ptr  (rd_ptr[ch]),
            .size (ent_size[ch]),
            .addr (rd_addr_v[ch])
        );
    end

    assign a_wr_addr   = wr_addr_v[0];
    assign a_rd_addr   = rd_addr_v[0];
    assign a_count     = count_v[0];
    assign a_not_empty = (count_v[0] != '0);
    assign a_ovf       = flags_v[0].ovf;
    assign a_unf       = flags_v[0].unf;

    assign b_wr_addr   = wr_addr_v[1];
    assign b_rd_addr   = rd_addr_v[1];
    assign b_count     = count_v[1];
    assign b_not_empty = (count_v[1] != '0);
    assign b_ovf       = flags_v[1].ovf;
    assign b_unf       = flags_v[1].unf;

endmodule

// File: rtl/rxq_addr_mgr_chk.sv
module rxq_addr_mgr_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_mode,
    input logic             cfg_we,
    input logic             cfg_err,
    input logic             a_push,
    input logic             a_pop,
    input logic [CNT_W-1:0] a_count,
    input logic             a_ovf,
    input logic             a_unf,
    input logic             b_push,
    input logic             b_pop,
    input logic [CNT_W-1:0] b_count,
    input logic             b_ovf,
    input logic             b_unf
);

    // R5
    bad_write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_mode) |=> cfg_err);

    // R5
    err_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(cfg_we && !cfg_mode));

    // R11
    cfg_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |=> (a_count == '0 && !a_ovf && !a_unf &&
                      b_count == '0 && !b_ovf && !b_unf));

    // R7
    a_ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (a_ovf && !cfg_mode) |=> a_ovf);

    // R7
    b_ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (b_ovf && !cfg_mode) |=> b_ovf);

    // R8
    a_unf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (a_pop && a_count == '0 && !cfg_mode) |=> a_unf);

    // R8
    b_unf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (b_pop && b_count == '0 && !cfg_mode) |=> b_unf);

    // R9
    a_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> (a_count == $past(a_count) ||
                       a_count == $past(a_count) + 1'b1 ||
                       a_count + 1'b1 == $past(a_count)));

    // R10
    b_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && !b_push && !b_pop) |=> (b_count == $past(b_count)));

    // R12
    a_empty_both_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && a_push && a_pop && a_count == '0) |=> (a_count == 1 && a_unf));

endmodule

bind rxq_addr_mgr rxq_addr_mgr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_mode(cfg_mode),
    .cfg_we  (cfg_we),
    .cfg_err (cfg_err),
    .a_push  (a_push),
    .a_pop   (a_pop),
    .a_count (a_count),
    .a_ovf   (a_ovf),
    .a_unf   (a_unf),
    .b_push  (b_push),
    .b_pop   (b_pop),
    .b_count (b_count),
    .b_ovf   (b_ovf),
    .b_unf   (b_unf)
);

// File: tb/test_rxq_addr_mgr.sv
module test_rxq_addr_mgr;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_mode = 1'b0, cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic cfg_err;
    logic a_push = 1'b0, a_pop = 1'b0, b_push = 1'b0, b_pop = 1'b0;
    logic [ADDR_W-1:0] a_wr_addr, a_rd_addr, b_wr_addr, b_rd_addr;
    logic a_not_empty, b_not_empty, a_ovf, a_unf, b_ovf, b_unf;
    logic [CNT_W-1:0] a_count, b_count;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rxq_addr_mgr i_rxq_addr_mgr (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .a_push(a_push), .a_pop(a_pop), .a_wr_addr(a_wr_addr), .a_rd_addr(a_rd_addr),
        .a_not_empty(a_not_empty), .a_count(a_count), .a_ovf(a_ovf), .a_unf(a_unf),
        .b_push(b_push), .b_pop(b_pop), .b_wr_addr(b_wr_addr), .b_rd_addr(b_rd_addr),
        .b_not_empty(b_not_empty), .b_count(b_count), .b_ovf(b_ovf), .b_unf(b_unf)
    );

    // ---------------- behavioural reference ----------------
    int m_mode, m_base_sys, m_base_q;
    int m_start[2], m_depth[2], m_size[2], m_wp[2], m_rp[2];
    bit m_ovf[2], m_unf[2], m_err;
    int m_fifo[2][$];

    function automatic int nxt(int p, int d);
        return (p == d - 1) ? 0 : p + 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_base_sys = 0; m_base_q = 0; m_err = 0;
            for (int c = 0; c < 2; c++) begin
                m_start[c] = 0; m_depth[c] = 0; m_size[c] = 0;
                m_wp[c] = 0; m_rp[c] = 0; m_ovf[c] = 0; m_unf[c] = 0;
                m_fifo[c].delete();
            end
        end else begin
            bit psh[2], pp[2];
            psh[0] = a_push; pp[0] = a_pop; psh[1] = b_push; pp[1] = b_pop;
            m_err = cfg_we && !cfg_mode;
            if (cfg_we && cfg_mode) begin
                case (int'(cfg_sel))
                    0: m_mode = int'(cfg_wdata[0]);
                    1: m_base_sys = int'(cfg_wdata);
                    2: m_base_q = int'(cfg_wdata);
                    3: m_start[0] = int'(cfg_wdata[7:0]);
                    4: begin m_size[0] = int'(cfg_wdata[7:0]); m_depth[0] = int'(cfg_wdata[15:8]); end
                    5: m_start[1] = int'(cfg_wdata[7:0]);
                    6: begin m_size[1] = int'(cfg_wdata[7:0]); m_depth[1] = int'(cfg_wdata[15:8]); end
                    default: ;
                endcase
            end
            for (int c = 0; c < 2; c++) begin
                if (cfg_mode) begin
                    m_wp[c] = 0; m_rp[c] = 0; m_ovf[c] = 0; m_unf[c] = 0;
                    m_fifo[c].delete();
                end else begin
                    int pre;
                    pre = m_fifo[c].size();
                    if (psh[c]) begin
                        if (pre == m_depth[c]) m_ovf[c] = 1;
                        else begin m_fifo[c].push_back(m_wp[c]); m_wp[c] = nxt(m_wp[c], m_depth[c]); end
                    end
                    if (pp[c]) begin
                        if (pre == 0) m_unf[c] = 1;
                        else begin void'(m_fifo[c].pop_front()); m_rp[c] = nxt(m_rp[c], m_depth[c]); end
                    end
                end
            end
        end
    end

    function automatic longint exp_addr(int c, int p);
        longint b;
        b = (m_mode != 0) ? m_base_q : m_base_sys;
        return (b + longint'(m_start[c] + p) * m_size[c]) & 64'hFFFF;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R5", "cfg_err", cfg_err, m_err);
        chk("R2,R3,R6", "a_wr_addr", a_wr_addr, exp_addr(0, m_wp[0]));
        chk("R2,R3,R6", "a_rd_addr", a_rd_addr, exp_addr(0, m_rp[0]));
        chk("R2,R10", "b_wr_addr", b_wr_addr, exp_addr(1, m_wp[1]));
        chk("R2,R10", "b_rd_addr", b_rd_addr, exp_addr(1, m_rp[1]));
        chk("R9,R12", "a_count", a_count, m_fifo[0].size());
        chk("R9,R10", "b_count", b_count, m_fifo[1].size());
        chk("R9", "a_not_empty", a_not_empty, m_fifo[0].size() != 0);
        chk("R9", "b_not_empty", b_not_empty, m_fifo[1].size() != 0);
        chk("R7", "a_ovf", a_ovf, m_ovf[0]);
        chk("R7", "b_ovf", b_ovf, m_ovf[1]);
        chk("R8,R12", "a_unf", a_unf, m_unf[0]);
        chk("R8", "b_unf", b_unf, m_unf[1]);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_reg(int sel, int data);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 16'(data);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic strobes(bit ap, bit aq, bit bp, bit bq);
        a_push = ap; a_pop = aq; b_push = bp; b_pop = bq;
        tick();
        a_push = 0; a_pop = 0; b_push = 0; b_pop = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        chk("R1", "reset a_wr_addr", a_wr_addr, 0);
        chk("R1", "reset b_count", b_count, 0);

        // R4: program both channels in configuration state
        cfg_mode = 1'b1;
        wr_reg(0, 0);
        wr_reg(1, 16'h1000);
        wr_reg(2, 16'h8000);
        wr_reg(3, 4);
        wr_reg(4, (3 << 8) | 16'h10);
        wr_reg(5, 20);
        wr_reg(6, (5 << 8) | 16'h28);
        cfg_mode = 1'b0;
        tick();
        // R3, R4: common base with mode bit 0: 0x1000 + 4*0x10
        chk("R4", "A start addr", a_wr_addr, 16'h1040);
        chk("R3", "B start addr", b_rd_addr, 16'h1000 + 20 * 16'h28);

        // R6, R7: fill A past its depth of 3, wrap the write pointer
        repeat (4) strobes(1, 0, 0, 0);
        // R8: pop empty B
        strobes(0, 0, 0, 1);
        // R12: full A with push and pop together
        strobes(1, 1, 0, 0);
        // R12: empty B with push and pop together
        strobes(0, 0, 1, 1);
        // R5: write outside configuration state is ignored
        wr_reg(1, 16'h2222);
        tick();
        chk("R5", "base unchanged", a_rd_addr, exp_addr(0, m_rp[0]));

        // R10: mixed random traffic
        for (int i = 0; i < 300; i++)
            strobes(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

        // R11: back to configuration state, strobes ignored, flags cleared
        cfg_mode = 1'b1;
        strobes(1, 0, 1, 0);
        chk("R11", "a_count in cfg", a_count, 0);
        wr_reg(0, 1);
        wr_reg(3, 16'hF0);
        wr_reg(4, (1 << 8) | 16'hFF);
        wr_reg(6, (0 << 8) | 16'h08);
        cfg_mode = 1'b0;
        tick();
        // R2: address wraps modulo 2^16: 0x8000 + 0xF0*0xFF
        chk("R2", "A wrapped addr", a_wr_addr, 16'h6F10);
        // R3: dedicated base selected
        chk("R3", "B addr dedicated base", b_wr_addr, 16'h8000 + 20 * 8);

        for (int i = 0; i < 200; i++)
            strobes(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        // R7: depth 0 on B, every push overflows
        strobes(0, 0, 1, 0);
        chk("R7", "B depth0 ovf", b_ovf, 1);

        summary();
        $finish;
    end

endmodule